// File: doc/BRIEF.md
# Snoop Control Unit Register Bank

This block is the software-visible register bank of a multicore cluster's snoop control unit. It sits on a simple single-cycle register bus that carries an offset, separate read and write strobes, an access size in bytes, and 32-bit write and read data. It holds a one-bit control register, a read-only configuration word derived from the core-count parameter, and a 32-bit per-core power status word. The power status word can be written in byte, halfword or word lanes starting at any of its four byte addresses.

Several locations exist only so that software probing them sees sane values: they read as zero and swallow writes. Any offset the bank does not decode also reads as zero, and an access to it raises a one-cycle flag so that the surrounding logic can log or trap the stray access. Snooping, cache maintenance, address filtering, access control and power sequencing are handled elsewhere. This block only stores and presents the values.

Top module: `scu_regbank`

## Requirements
- R1: A write to offset 0x00 keeps only bit 0 of the write data. A read of 0x00 returns that bit in bit 0 and zero in bits 31:1.
- R2: A read of offset 0x04 returns ones in bits [3+NUM_CORES:4], NUM_CORES-1 in bits [1:0] and zero elsewhere (0x000000F3 for four cores). Writes to 0x04 change nothing.
- R3: A read at offset 0x08, 0x09, 0x0A or 0x0B returns the power status word shifted right by 0, 8, 16 or 24 bits respectively, with zeros filled in from the top.
- R4: A write at offset 0x08+k (k = 0..3) with size_i of 1, 2 or 4 replaces the bits of the power word selected by the mask 0xFF, 0xFFFF or 0xFFFFFFFF shifted left by 8*k. The new bits come from the matching low bits of wdata_i. Mask bits shifted above bit 31 are dropped.
- R5: A write whose size_i is not 1, 2 or 4 changes no register.
- R6: Offsets 0x0C, 0x40 and 0x44 read as zero, ignore writes and do not raise unimp_o.
- R7: Any offset not named in R1–R4 or R6 reads as zero. A read or write to it sets unimp_o high in the following cycle only.
- R8: After reset the control bit and the power word are zero, and rdata_o and unimp_o are low.
- R9: rdata_o carries the read result in the cycle after rd_en_i and is zero in every cycle that does not follow a read. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| size_i | input | 3 | Access size in bytes; 1, 2 and 4 are valid |
| wdata_i | input | 32 | Write data, low-aligned |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| unimp_o | output | 1 | One-cycle pulse after an access to an undecoded offset |

## Verification
A read and a write can hit the same power status lane in the same cycle. The bench drives rd_en_i and wr_en_i together at offset 0x08 with a new word. It expects the old word on rdata_o in the next cycle, and then reads again to see the new word. A second case puts a read and a write together on an undecoded offset and expects exactly one pulse of unimp_o, which must drop in the following idle cycle.

// File: rtl/scu_pkg.sv
`timescale 1ns/1ps
package scu_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_CFG    = 8'h04;
  localparam logic [7:0] OFF_PWR    = 8'h08;
  localparam logic [7:0] OFF_INVAL  = 8'h0C;
  localparam logic [7:0] OFF_FLT_LO = 8'h40;
  localparam logic [7:0] OFF_FLT_HI = 8'h44;

  typedef enum logic [2:0] {
    RG_CTRL,
    RG_CFG,
    RG_PWR,
    RG_RAZ,
    RG_UNIMP
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [1:0] lane;
  } dec_t;
endpackage

// File: rtl/scu_addr_decode.sv
`timescale 1ns/1ps
module scu_addr_decode
  import scu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(OFF_PWR);
  localparam logic [ADDR_W-1:0] A_INVAL  = ADDR_W'(OFF_INVAL);
  localparam logic [ADDR_W-1:0] A_FLT_LO = ADDR_W'(OFF_FLT_LO);
  localparam logic [ADDR_W-1:0] A_FLT_HI = ADDR_W'(OFF_FLT_HI);

  always_comb begin
    dec_o.lane = addr_i[1:0];
    if (addr_i == A_CTRL)
      dec_o.region = RG_CTRL;
    else if (addr_i == A_CFG)
      dec_o.region = RG_CFG;
    else if (addr_i[ADDR_W-1:2] == A_PWR[ADDR_W-1:2])
      dec_o.region = RG_PWR;  // any byte of the power word
    else if (addr_i == A_INVAL || addr_i == A_FLT_LO || addr_i == A_FLT_HI)
      dec_o.region = RG_RAZ;
    else
      dec_o.region = RG_UNIMP;
  end
endmodule

// File: rtl/scu_lane_writer.sv
`timescale 1ns/1ps
module scu_lane_writer
  import scu_pkg::*;
(
  input  logic [2:0]        size_i,
  input  logic [1:0]        lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              size_ok_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] base;
  logic [4:0]        shamt;

  always_comb begin
    size_ok_o = 1'b1;
    unique case (size_i)
      3'd1:    base = DATA_W'(32'h0000_00FF);
      3'd2:    base = DATA_W'(32'h0000_FFFF);
      3'd4:    base = '1;
      default: begin
        base      = '0;
        size_ok_o = 1'b0;
      end
    endcase
    shamt  = {lane_i, 3'b000};
    // bits pushed past the MSB fall off
    mask_o = base << shamt;
    data_o = (wdata_i & base) << shamt;
  end
endmodule

// File: rtl/scu_pwr_word.sv
`timescale 1ns/1ps
module scu_pwr_word
  import scu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      q_o <= '0;
    else if (we_i)
      q_o <= (q_o & ~mask_i) | (data_i & mask_i);
  end
endmodule

// File: rtl/scu_regbank.sv
`timescale 1ns/1ps
module scu_regbank
  import scu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              unimp_o
);
  localparam int unsigned CNT_W = 2;
  localparam int unsigned MAP_LSB = 4;

  dec_t              dec;
  logic              size_ok;
  logic [DATA_W-1:0] lane_mask, lane_data;
  logic [DATA_W-1:0] pwr_q;
  logic              ctrl_q;
  logic [DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ok;

  scu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  scu_lane_writer u_lane (
    .size_i    (size_i),
    .lane_i    (dec.lane),
    .wdata_i   (wdata_i),
    .size_ok_o (size_ok),
    .mask_o    (lane_mask),
    .data_o    (lane_data)
  );

  assign wr_ok = wr_en_i & size_ok;

  scu_pwr_word u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ok && dec.region == RG_PWR),
    .mask_i (lane_mask),
    .data_i (lane_data),
    .q_o    (pwr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ctrl_q <= 1'b0;
    else if (wr_ok && dec.region == RG_CTRL)
      ctrl_q <= wdata_i[0];
  end

  // configuration word: core-present map plus count-1
  for (genvar b = 0; b < DATA_W; b++) begin : g_cfg
    if (b >= MAP_LSB && b < MAP_LSB + NUM_CORES) begin : g_map
      assign cfg_word[b] = 1'b1;
    end else if (b < CNT_W) begin : g_cnt
      assign cfg_word[b] = CNT_W'(NUM_CORES - 1) >> b & 1'b1;
    end else begin : g_zero
      assign cfg_word[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (dec.region)
      RG_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, ctrl_q};
      RG_CFG:  rd_mux = cfg_word;
      RG_PWR:  rd_mux = pwr_q >> {dec.lane, 3'b000};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      unimp_o <= 1'b0;
    end else begin
      rdata_o <= rd_en_i ? rd_mux : '0;
      unimp_o <= (rd_en_i | wr_en_i) && dec.region == RG_UNIMP;
    end
  end
endmodule

// File: rtl/scu_regbank_chk.sv
`timescale 1ns/1ps
module scu_regbank_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CORES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [2:0]        size_i,
  input logic [31:0]       rdata_o,
  input logic              unimp_o,
  input logic [31:0]       pwr_q
);
  localparam logic [31:0] CFG_EXP =
    32'(((1 << NUM_CORES) - 1) << 4) | 32'(NUM_CORES - 1);

  logic listed, raz, bad_size;
  always_comb begin
    raz = addr_i == ADDR_W'(8'h0C) || addr_i == ADDR_W'(8'h40) ||
          addr_i == ADDR_W'(8'h44);
    listed = raz || addr_i == ADDR_W'(8'h00) || addr_i == ADDR_W'(8'h04) ||
             addr_i == ADDR_W'(8'h08) || addr_i == ADDR_W'(8'h09) ||
             addr_i == ADDR_W'(8'h0A) || addr_i == ADDR_W'(8'h0B);
    bad_size = !(size_i == 3'd1 || size_i == 3'd2 || size_i == 3'd4);
  end

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(8'h00) |=> rdata_o[31:1] == '0); // R1

  AST_CFG_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(8'h04) |=> rdata_o == CFG_EXP); // R2

  AST_PWR_TOP_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(8'h0B) |=> rdata_o[31:8] == '0); // R3

  AST_BAD_SIZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && bad_size |=> $stable(pwr_q)); // R5

  AST_RAZ_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && raz |=> rdata_o == '0 && !unimp_o); // R6

  AST_UNIMP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i || wr_en_i) && !listed |=> unimp_o && rdata_o == '0); // R7

  AST_UNIMP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i || wr_en_i) |=> !unimp_o); // R7

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0); // R9
endmodule

bind scu_regbank scu_regbank_chk #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .size_i  (size_i),
  .rdata_o (rdata_o),
  .unimp_o (unimp_o),
  .pwr_q   (pwr_q)
);

// File: tb/tb_scu_regbank.sv
`timescale 1ns/1ps
module tb_scu_regbank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  size_i = 3'd4;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        unimp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  scu_regbank #(.ADDR_W(8), .NUM_CORES(4)) dut (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .size_i, .wdata_i, .rdata_o, .unimp_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; size_i = sz; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R8 rdata", rdata_o, 32'h0);
    check("R8 unimp", {31'b0, unimp_o}, 32'h0);
    rd(8'h00, d); check("R8 ctrl", d, 32'h0);
    rd(8'h08, d); check("R8 pwr", d, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R1 set", d, 32'h1);
    wr(8'h00, 3'd4, 32'hFFFF_FFFE);
    rd(8'h00, d); check("R1 clear", d, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    rd(8'h04, d); check("R2 cfg", d, 32'h0000_00F3);
    wr(8'h04, 3'd4, 32'h0);
    check("R2 no unimp", {31'b0, unimp_o}, 32'h0);
    rd(8'h04, d); check("R2 cfg after write", d, 32'h0000_00F3);
  endtask

  task automatic t_pwr();
    logic [31:0] d;
    wr(8'h08, 3'd4, 32'hAABB_CCDD);
    rd(8'h08, d); check("R4 word", d, 32'hAABB_CCDD);
    wr(8'h0A, 3'd1, 32'hFFFF_FF11);
    rd(8'h08, d); check("R4 byte lane2", d, 32'hAA11_CCDD);
    wr(8'h0B, 3'd2, 32'h0000_5566);
    rd(8'h08, d); check("R4 half overflow", d, 32'h6611_CCDD);
    wr(8'h09, 3'd4, 32'h0102_0304);
    rd(8'h08, d); check("R4 word at lane1", d, 32'h0203_04DD);
    wr(8'h08, 3'd2, 32'h1234_BEEF);
    rd(8'h08, d); check("R4 half lane0", d, 32'h0203_BEEF);
    rd(8'h09, d); check("R3 shift8", d, 32'h0002_03BE);
    rd(8'h0A, d); check("R3 shift16", d, 32'h0000_0203);
    rd(8'h0B, d); check("R3 shift24", d, 32'h0000_0002);
  endtask

  task automatic t_bad_size();
    logic [31:0] d;
    wr(8'h08, 3'd3, 32'hFFFF_FFFF);
    wr(8'h09, 3'd0, 32'h0);
    rd(8'h08, d); check("R5 pwr", d, 32'h0203_BEEF);
    wr(8'h00, 3'd5, 32'h1);
    rd(8'h00, d); check("R5 ctrl", d, 32'h0);
  endtask

  task automatic t_raz();
    logic [31:0] d;
    logic [7:0] offs [3] = '{8'h0C, 8'h40, 8'h44};
    foreach (offs[i]) begin
      wr(offs[i], 3'd4, 32'hFFFF_FFFF);
      check("R6 no unimp on write", {31'b0, unimp_o}, 32'h0);
      rd(offs[i], d);
      check("R6 read zero", d, 32'h0);
      check("R6 no unimp on read", {31'b0, unimp_o}, 32'h0);
    end
    rd(8'h08, d); check("R6 pwr untouched", d, 32'h0203_BEEF);
  endtask

  task automatic t_unimp();
    logic [31:0] d;
    rd(8'h50, d);
    check("R7 read zero", d, 32'h0);
    check("R7 pulse on read", {31'b0, unimp_o}, 32'h1);
    @(negedge clk_i);
    check("R7 pulse drops", {31'b0, unimp_o}, 32'h0);
    wr(8'h54, 3'd4, 32'h1);
    check("R7 pulse on write", {31'b0, unimp_o}, 32'h1);
    rd(8'h02, d);
    check("R7 unaligned ctrl zero", d, 32'h0);
    check("R7 unaligned ctrl flag", {31'b0, unimp_o}, 32'h1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk_i);
    addr_i = 8'h08; size_i = 3'd4; wdata_i = 32'h1234_5678;
    rd_en_i = 1'b1; wr_en_i = 1'b1;
    @(negedge clk_i);
    check("R9 read before write", rdata_o, 32'h0203_BEEF);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    @(negedge clk_i);
    check("R9 idle rdata zero", rdata_o, 32'h0);
    rd(8'h08, d); check("R9 write landed", d, 32'h1234_5678);
    @(negedge clk_i);
    addr_i = 8'h60; rd_en_i = 1'b1; wr_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    check("R7 combined access pulse", {31'b0, unimp_o}, 32'h1);
    @(negedge clk_i);
    check("R7 combined access single", {31'b0, unimp_o}, 32'h0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ctrl();
    t_cfg();
    t_pwr();
    t_bad_size();
    t_raz();
    t_unimp();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule